// File: doc/BRIEF.md
# Signal Crossbar with Edge-Triggered DMA Requests

This block routes any one of `N_IN` single-bit event signals to each of `N_OUT` crossbar outputs. Each output has its own select field, so several outputs can follow the same input at once. Each output also has its own edge detector. When the detector is enabled, it turns a chosen transition of the routed signal into a request for a downstream DMA channel. The request is held pending until the DMA engine returns an acknowledge. One timer or event line can therefore start transfers on two or more channels. For example, outputs 0 and 1 can both select input 32, and they then feed DMA request lines 30 and 31 of the channel multiplexer.

Configuration is written through a narrow write port. Address bit `ADDR_W-1` chooses the bank: 0 for select registers, 1 for control registers. The lower bits choose an output pair. Each 16-bit register word holds one byte per output. The low byte belongs to the even output (2p) and the high byte to the odd output (2p+1). All inputs are assumed to be synchronous to `clk`.

Top module: `xbar_dma_trig`

## Requirements
- R1: After reset every select field is 0, every control byte is 0, and all `dma_req` and `req_flag` bits are low. Every `xbar_out` bit then follows `trig_in[0]`.
- R2: `xbar_out[k]` equals `trig_in[s]`, where `s` is the low `$clog2(N_IN)` bits of output k's select byte. Upper select-byte bits are ignored. A write of 0x20 routes input 32.
- R3: When several outputs select the same input, each output raises, holds and clears its own request independently of the others.
- R4: In a control byte, bit 0 enables request generation and bits 2:1 give the edge code. The codes are: 10 = rising, 01 = falling, 11 = both, 00 = none. A byte of 0x05 therefore means enabled on the rising edge.
- R5: An edge is a difference between the routed signal in this cycle and its value one cycle earlier. An enabled output whose code matches that edge sets `req_flag` and `dma_req` at the next clock edge.
- R6: `dma_ack[k]` clears output k's pending request at the next clock edge. Further edges that arrive while a request is pending merge into it, so one acknowledge clears it. An edge in the same cycle as the acknowledge leaves the request set.
- R7: While output k is disabled, `dma_req[k]` is low and `req_flag[k]` holds its value, ignoring both edges and acknowledges. Re-enabling the output exposes a held flag again on `dma_req[k]`.
- R8: Edge code 00 never raises a request, even when the output is enabled.
- R9: A register write changes only the byte pair addressed by bank and pair index. Control writes leave routing unchanged, and select writes leave control unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossbar clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | {bank, pair index}; bank 0 select, bank 1 control |
| wr_data | input | 16 | Two per-output bytes; low byte is the even output |
| trig_in | input | N_IN | Event signals to route |
| dma_ack | input | N_OUT | Per-output acknowledge from the DMA engine |
| xbar_out | output | N_OUT | Routed signal of each output |
| dma_req | output | N_OUT | Pending request, gated by the output's enable |
| req_flag | output | N_OUT | Sticky pending status of each output |

## Verification
Four properties are checked on every cycle:
- an enabled matching edge sets the flag one cycle later;
- the flag never rises without such an edge;
- an acknowledge with no competing edge clears the flag, and a disabled output's flag stays frozen;
- code 00 never yields an edge event.

Several behaviours can only be shown by the bench's scenarios:
- the byte layout of the select and control words, and routing to a chosen input index;
- the mapping of each edge code to a physical transition;
- independent requests from a shared input;
- merging of several edges into one request;
- re-exposure of a held flag after re-enabling.

// File: rtl/xbar_dma_pkg.sv
package xbar_dma_pkg;

  // Edge code held in bits 2:1 of each control byte
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_code_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_EDGE_LSB = 1;
  localparam int DATA_W        = 16;

  // Does the transition prev->cur match the code?
  function automatic logic edge_hit(edge_code_e code, logic prev, logic cur);
    case (code)
      EDGE_RISE: return ~prev & cur;
      EDGE_FALL: return prev & ~cur;
      EDGE_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

  // Next value of a pending flag
  function automatic logic flag_next(logic en, logic flag, logic ack, logic hit);
    if (!en) return flag;
    return (flag & ~ack) | hit;
  endfunction

endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs #(
  parameter int N_OUT  = 4,
  parameter int SEL_W  = 6,
  parameter int PAIR_W = 1,
  localparam int ADDR_W = PAIR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [15:0]              wr_data,
  output logic [N_OUT*SEL_W-1:0]   sel_flat,
  output logic [N_OUT-1:0]         ctrl_en,
  output logic [2*N_OUT-1:0]       ctrl_code
);
  import xbar_dma_pkg::*;

  logic bank;
  logic [PAIR_W-1:0] pair;
  assign bank = wr_addr[ADDR_W-1];
  assign pair = wr_addr[PAIR_W-1:0];

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int HALF = k % 2;
    localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(k / 2);
    logic [7:0] lane;
    logic       hit_pair;
    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    logic [1:0]       code_q;

    assign lane     = wr_data[8*HALF +: 8];
    assign hit_pair = wr_en && (pair == MY_PAIR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q  <= '0;
        en_q   <= 1'b0;
        code_q <= EDGE_NONE;
      end else if (hit_pair) begin
        if (!bank) sel_q <= lane[SEL_W-1:0];
        else begin
          en_q   <= lane[CTRL_EN_BIT];
          code_q <= lane[CTRL_EDGE_LSB +: 2];
        end
      end
    end

    assign sel_flat[k*SEL_W +: SEL_W] = sel_q;
    assign ctrl_en[k]                 = en_q;
    assign ctrl_code[2*k +: 2]        = code_q;
  end

endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int N_IN  = 64,
  parameter int N_OUT = 4,
  parameter int SEL_W = 6
) (
  input  logic [N_IN-1:0]        trig_in,
  input  logic [N_OUT*SEL_W-1:0] sel_flat,
  output logic [N_OUT-1:0]       routed
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_mux
    assign routed[k] = trig_in[sel_flat[k*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/xbar_edge_unit.sv
module xbar_edge_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig,
  input  logic       en,
  input  logic [1:0] code,
  input  logic       ack,
  output logic       edge_evt,
  output logic       flag,
  output logic       req
);
  import xbar_dma_pkg::*;

  logic prev_q;
  logic flag_q;

  assign edge_evt = edge_hit(edge_code_e'(code), prev_q, sig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sig;
      flag_q <= flag_next(en, flag_q, ack, edge_evt);
    end
  end

  assign flag = flag_q;
  assign req  = flag_q & en;
endmodule

// File: rtl/xbar_dma_trig.sv
module xbar_dma_trig #(
  parameter int N_IN  = 64,
  parameter int N_OUT = 4,
  localparam int SEL_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int N_PAIR = (N_OUT + 1) / 2,
  localparam int PAIR_W = (N_PAIR > 1) ? $clog2(N_PAIR) : 1,
  localparam int ADDR_W = PAIR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [N_IN-1:0]   trig_in,
  input  logic [N_OUT-1:0]  dma_ack,
  output logic [N_OUT-1:0]  xbar_out,
  output logic [N_OUT-1:0]  dma_req,
  output logic [N_OUT-1:0]  req_flag
);

  logic [N_OUT*SEL_W-1:0] sel_flat;
  logic [N_OUT-1:0]       ctrl_en;
  logic [2*N_OUT-1:0]     ctrl_code;
  logic [N_OUT-1:0]       edge_evt;

  xbar_cfg_regs #(.N_OUT(N_OUT), .SEL_W(SEL_W), .PAIR_W(PAIR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_flat(sel_flat), .ctrl_en(ctrl_en),
    .ctrl_code(ctrl_code)
  );

  xbar_route #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_route (
    .trig_in(trig_in), .sel_flat(sel_flat), .routed(xbar_out)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_edge
    xbar_edge_unit u_edge (
      .clk(clk), .rst_n(rst_n), .sig(xbar_out[k]), .en(ctrl_en[k]),
      .code(ctrl_code[2*k +: 2]), .ack(dma_ack[k]),
      .edge_evt(edge_evt[k]), .flag(req_flag[k]), .req(dma_req[k])
    );
  end

endmodule

// File: rtl/xbar_dma_trig_chk.sv
module xbar_dma_trig_chk #(
  parameter int N_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_OUT-1:0]   dma_ack,
  input logic [N_OUT-1:0]   req_flag,
  input logic [N_OUT-1:0]   edge_evt,
  input logic [N_OUT-1:0]   ctrl_en,
  input logic [2*N_OUT-1:0] ctrl_code
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    // R5: enabled matching edge sets the flag on the next edge
    assert_edge_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en[k] && edge_evt[k]) |=> req_flag[k]);
    // R5: flag only rises after an enabled edge event
    assert_flag_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_flag[k]) |-> $past(ctrl_en[k] && edge_evt[k]));
    // R6: acknowledge without competing edge clears the flag
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en[k] && dma_ack[k] && !edge_evt[k]) |=> !req_flag[k]);
    // R7: disabled output keeps its flag frozen
    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en[k] |=> $stable(req_flag[k]));
    // R8: code 00 yields no edge event
    assert_code_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_code[2*k +: 2] == 2'b00) |-> !edge_evt[k]);
  end
endmodule

bind xbar_dma_trig xbar_dma_trig_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_ack(dma_ack), .req_flag(req_flag),
  .edge_evt(edge_evt), .ctrl_en(ctrl_en), .ctrl_code(ctrl_code)
);

// File: tb/xbar_dma_trig_test.sv
module xbar_dma_trig_test;
  localparam int NI = 64;
  localparam int NO = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [15:0]   wr_data;
  logic [NI-1:0] trig;
  logic [NO-1:0] ack;
  wire  [NO-1:0] xo, req, flg;

  xbar_dma_trig #(.N_IN(NI), .N_OUT(NO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig), .dma_ack(ack),
    .xbar_out(xo), .dma_req(req), .req_flag(flg)
  );

  typedef struct {
    string      tag;
    logic [3:0] req;
    logic [3:0] flg;
    logic [3:0] xo;
  } exp_t;

  exp_t sbq[$];
  event smp;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  int   sel_m[NO];

  function automatic logic [3:0] route();
    logic [3:0] r;
    for (int k = 0; k < NO; k++) r[k] = trig[sel_m[k]];
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // bank 0 = select, bank 1 = control; low byte = even output
  task automatic wr(input logic bank, input logic pair, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = {bank, pair}; wr_data = d;
    step();
    wr_en = 1'b0;
    if (!bank) begin
      sel_m[2*pair]   = int'(d[5:0]);
      sel_m[2*pair+1] = int'(d[13:8]);
    end
  endtask

  task automatic expect_now(input string tag, input logic [3:0] r, input logic [3:0] f);
    exp_t e;
    e.tag = tag; e.req = r; e.flg = f; e.xo = route();
    sbq.push_back(e);
    -> smp;
    #1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(smp);
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_chk++;
        if (req !== e.req || flg !== e.flg || xo !== e.xo) begin
          n_fail++;
          $display("FAIL %s: req=%b flag=%b out=%b, expected req=%b flag=%b out=%b",
                   e.tag, req, flg, xo, e.req, e.flg, e.xo);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin : driver
    for (int k = 0; k < NO; k++) sel_m[k] = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack = '0;
    trig = '0; trig[0] = 1'b1;
    step(); step();
    rst_n = 1'b1;
    step();
    expect_now("R1 reset state", 4'b0000, 4'b0000);

    // Routing: outs 0,1 <- input 32; out2 <- 5 (upper bits set); out3 <- 3
    wr(1'b0, 1'b0, 16'h2020);
    wr(1'b0, 1'b1, 16'h03C5);
    trig[0] = 1'b0; trig[5] = 1'b1; step();
    expect_now("R2 routing, input 5 high", 4'b0000, 4'b0000);
    trig[5] = 1'b0; trig[3] = 1'b1; step();
    expect_now("R2 routing, input 3 high", 4'b0000, 4'b0000);
    trig[3] = 1'b0; step();

    // Control pair0 = 0x0505 : both enabled, rising
    wr(1'b1, 1'b0, 16'h0505);
    expect_now("R9 control write keeps routing", 4'b0000, 4'b0000);
    trig[32] = 1'b1; step();
    expect_now("R3 R5 rising edge on shared input", 4'b0011, 4'b0011);
    ack = 4'b0001; step(); ack = '0;
    expect_now("R3 R6 ack out0 only", 4'b0010, 4'b0010);
    trig[32] = 1'b0; step();
    expect_now("R4 falling ignored by rising code", 4'b0010, 4'b0010);

    // Merge several edges into one pending request
    trig[32] = 1'b1; step();
    trig[32] = 1'b0; step();
    trig[32] = 1'b1; step();
    expect_now("R6 merged edges pending", 4'b0011, 4'b0011);
    ack = 4'b0011; step(); ack = '0;
    expect_now("R6 single ack clears merged", 4'b0000, 4'b0000);

    // Edge together with ack
    trig[32] = 1'b0; step();
    ack = 4'b0001; trig[32] = 1'b1; step(); ack = '0;
    expect_now("R6 edge wins over ack", 4'b0011, 4'b0011);
    ack = 4'b0011; step(); ack = '0;
    expect_now("R6 cleared", 4'b0000, 4'b0000);

    // pair1: out2 byte 0x03 falling, out3 byte 0x07 both
    wr(1'b1, 1'b1, 16'h0703);
    trig[5] = 1'b1; step();
    expect_now("R4 rise ignored by falling code", 4'b0000, 4'b0000);
    trig[5] = 1'b0; step();
    expect_now("R4 falling code", 4'b0100, 4'b0100);
    trig[3] = 1'b1; step();
    expect_now("R4 both code rising", 4'b1100, 4'b1100);
    ack = 4'b1100; step(); ack = '0;
    trig[3] = 1'b0; step();
    expect_now("R4 both code falling", 4'b1000, 4'b1000);
    ack = 4'b1000; step(); ack = '0;

    // Code 00 with enable
    wr(1'b1, 1'b1, 16'h0101);
    trig[5] = 1'b1; trig[3] = 1'b1; step();
    trig[5] = 1'b0; trig[3] = 1'b0; step();
    expect_now("R8 code none no request", 4'b0000, 4'b0000);

    // Disable with pending flag
    trig[32] = 1'b0; step();
    trig[32] = 1'b1; step();
    ack = 4'b0001; step(); ack = '0;
    expect_now("R7 setup out1 pending", 4'b0010, 4'b0010);
    wr(1'b1, 1'b0, 16'h0004);
    expect_now("R7 disabled req low, flag held", 4'b0000, 4'b0010);
    ack = 4'b0010; step(); ack = '0;
    expect_now("R7 ack ignored while disabled", 4'b0000, 4'b0010);
    trig[32] = 1'b0; step();
    trig[32] = 1'b1; step();
    expect_now("R7 edge ignored while disabled", 4'b0000, 4'b0010);
    wr(1'b1, 1'b0, 16'h0505);
    expect_now("R7 re-enable exposes held flag", 4'b0010, 4'b0010);
    ack = 4'b0010; step(); ack = '0;
    expect_now("R7 cleared after re-enable", 4'b0000, 4'b0000);

    step();
    finish_run();
  end
endmodule